// File: doc/BRIEF.md
# Protected Timer Control Register

This block is the control and status register of a low-power timer whose counter runs on a slow clock. Software reaches it through a simple register port on the bus clock: a write strobe, write data and read data that always shows the current state. It holds a write-protect key, three enable bits (timer run, long-interval alarm and short-interval alarm), a ready flag that follows counter updates, two alarm flags and a ready interrupt enable. From these it drives an interrupt line and a wake-up line.

The three enable bits are first held in a bus-side shadow. Whenever the shadow changes, the new value is carried into the slow domain by a toggle handshake. Each direction of that handshake passes through a synchronizer chain, and a busy bit stays high until the acknowledge comes back. Only then do the slow-domain enable outputs and the bus-side effective copy that gates the alarm interrupts hold the new value. The run bit is guarded: a write to it takes effect only when the key bit is already set and no transfer is in progress. The counter-update strobes and alarm-match pulses are produced by logic outside this block and arrive already synchronized to the bus clock.

Top module: `tcr_ctl`

## Requirements
- R1: After reset the register reads 0x0000, irq_o and wake_o are 0, and all three slow-domain enable outputs are 0.
- R2: A write to bit 0 (timer run) is dropped when the stored key bit 15 is 0, or when busy (bit 3) is 1 at the moment of the write.
- R3: A write to bit 0 is accepted when the stored key bit 15 is 1 and busy is 0. Bit 15 itself can be written freely.
- R4: A write that changes any of bits 0, 1 or 2 sets busy (bit 3) from the next cycle. Busy returns to 0 by itself once the acknowledge arrives. Bit 3 is read-only, and a write that changes none of the enable bits leaves busy at 0.
- R5: By the time busy has returned to 0, the slow-domain outputs run_o, long_en_o and short_en_o equal the values written to bits 0, 1 and 2.
- R6: The alarm enables that gate irq_o take a new written value only when busy falls. Until then, the previous value keeps gating the interrupt.
- R7: The ready flag (bit 4) is set by an update strobe, cleared by a pre-update strobe, and cleared by software writing 0 to it. Writing 1 to it never sets it.
- R8: The long and short alarm flags (bits 6 and 7) are set by their alarm pulses and cleared by writing 0 to them. Writing 1 leaves them unchanged, and a pulse that coincides with a clearing write wins.
- R9: irq_o is the OR of: (long flag AND effective long enable), (short flag AND effective short enable), and (ready flag AND ready interrupt enable, bit 5).
- R10: wake_o is 1 exactly when at least one alarm flag is pending, whatever the enables are.
- R11: Bits 8 to 14 always read 0, even after writing ones to them.
- R12: An update strobe in the same cycle as a pre-update strobe or a software clear of the ready flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus-domain reset, active low |
| slow_clk_i | input | 1 | Timer clock |
| slow_rst_ni | input | 1 | Timer-domain reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Register read value |
| cnt_pre_i | input | 1 | Pulse one cycle before a counter update |
| cnt_upd_i | input | 1 | Counter update strobe |
| alm_long_i | input | 1 | Long-interval alarm match pulse |
| alm_short_i | input | 1 | Short-interval alarm match pulse |
| run_o | output | 1 | Timer run enable, timer domain |
| long_en_o | output | 1 | Long alarm enable, timer domain |
| short_en_o | output | 1 | Short alarm enable, timer domain |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The bench builds the block with two synchronizer stages per direction. The slow clock has a period of 37 ns, against 5 ns on the bus side, so one transfer keeps busy high for roughly twenty bus cycles. That window is long enough to issue a second write while busy is still high, which exercises the run-bit guard. It also lets the bench observe irq_o still gated by the old alarm enable before the effective copy switches over.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int DATA_W   = 16;
  localparam int EN_W     = 3;   // run, long enable, short enable
  localparam int FLAG_W   = 3;   // ready, long flag, short flag

  // bit positions in the register
  localparam int B_RUN    = 0;
  localparam int B_LEN    = 1;
  localparam int B_SEN    = 2;
  localparam int B_BUSY   = 3;
  localparam int B_RDY    = 4;
  localparam int B_RDYIE  = 5;
  localparam int B_LFLAG  = 6;
  localparam int B_SFLAG  = 7;
  localparam int B_KEY    = 15;

  // index inside the enable bundle and the flag vector
  localparam int E_RUN = 0;
  localparam int E_LEN = 1;
  localparam int E_SEN = 2;
  localparam int F_RDY = 0;
  localparam int F_LNG = 1;
  localparam int F_SHT = 2;

  function automatic int flag_pos(input int idx);
    int p;
    case (idx)
      F_RDY:   p = B_RDY;
      F_LNG:   p = B_LFLAG;
      default: p = B_SFLAG;
    endcase
    return p;
  endfunction

  function automatic logic irq_calc(input logic [FLAG_W-1:0] fl,
                                    input logic [EN_W-1:0]   eff,
                                    input logic              rdy_ie);
    return (fl[F_LNG] & eff[E_LEN]) | (fl[F_SHT] & eff[E_SEN]) |
           (fl[F_RDY] & rdy_ie);
  endfunction

  function automatic logic [DATA_W-1:0] pack_reg(input logic [EN_W-1:0]   en,
                                                 input logic              busy,
                                                 input logic [FLAG_W-1:0] fl,
                                                 input logic              rdy_ie,
                                                 input logic              key);
    logic [DATA_W-1:0] r;
    r = '0;
    r[B_RUN]   = en[E_RUN];
    r[B_LEN]   = en[E_LEN];
    r[B_SEN]   = en[E_SEN];
    r[B_BUSY]  = busy;
    r[B_RDY]   = fl[F_RDY];
    r[B_RDYIE] = rdy_ie;
    r[B_LFLAG] = fl[F_LNG];
    r[B_SFLAG] = fl[F_SHT];
    r[B_KEY]   = key;
    return r;
  endfunction
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/tcr_flag.sv
module tcr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic sw_wr_i,
  input  logic sw_val_i,
  output logic flag_o
);
  logic flag_q;
  logic sw_clr;

  assign sw_clr = sw_wr_i & ~sw_val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (set_i)              flag_q <= 1'b1;
    else if (hw_clr_i || sw_clr) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R8 / R12: a set event always wins over any clear in the same cycle
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  // R7: a hardware clear without a set leaves the flag low
  p_hwclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_i && !set_i) |=> !flag_o);

  // R7 / R8: writing 1 never raises a flag that no event set
  p_sw_noset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/tcr_xfer.sv
module tcr_xfer #(
  parameter int W           = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         slow_clk_i,
  input  logic         slow_rst_ni,
  input  logic         pend_i,
  input  logic [W-1:0] data_i,
  output logic         launch_o,
  output logic         inflight_o,
  output logic [W-1:0] eff_o,
  output logic [W-1:0] slow_o
);
  // bus side
  logic         req_q;
  logic         inflight_q;
  logic [W-1:0] bundle_q;
  logic [W-1:0] eff_q;
  logic         ack_sync;
  logic         ack_seen_q;
  logic         done;

  // slow side
  logic         req_sync;
  logic         ack_q;
  logic [W-1:0] slow_q;

  assign launch_o = pend_i & ~inflight_q;
  assign done     = inflight_q & (ack_sync != ack_seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      inflight_q <= 1'b0;
      bundle_q   <= '0;
      eff_q      <= '0;
      ack_seen_q <= 1'b0;
    end else begin
      if (launch_o) begin
        req_q      <= ~req_q;
        inflight_q <= 1'b1;
        bundle_q   <= data_i;
      end else if (done) begin
        inflight_q <= 1'b0;
        ack_seen_q <= ack_sync;
        eff_q      <= bundle_q;
      end
    end
  end

  tcr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (slow_clk_i),
    .rst_ni (slow_rst_ni),
    .d_i    (req_q),
    .q_o    (req_sync)
  );

  always_ff @(posedge slow_clk_i or negedge slow_rst_ni) begin
    if (!slow_rst_ni) begin
      ack_q  <= 1'b0;
      slow_q <= '0;
    end else if (req_sync != ack_q) begin
      ack_q  <= req_sync;
      slow_q <= bundle_q;
    end
  end

  tcr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_q),
    .q_o    (ack_sync)
  );

  assign inflight_o = inflight_q;
  assign eff_o      = eff_q;
  assign slow_o     = slow_q;

  // R5: the bundle seen by the slow domain holds still while a transfer is open
  p_bundle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inflight_q && !done) |=> $stable(bundle_q));

  // R6: the effective copy only moves when a transfer completes
  p_eff_only_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(eff_q));
endmodule

// File: rtl/tcr_ctl.sv
module tcr_ctl
  import tcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic              slow_rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cnt_pre_i,
  input  logic              cnt_upd_i,
  input  logic              alm_long_i,
  input  logic              alm_short_i,
  output logic              run_o,
  output logic              long_en_o,
  output logic              short_en_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic              key_q;
  logic              rdy_ie_q;
  logic [EN_W-1:0]   shadow_q;
  logic [EN_W-1:0]   shadow_d;
  logic              pend_q;
  logic              busy;
  logic              run_wr_ok;
  logic              en_change;
  logic              launch;
  logic              inflight;
  logic [EN_W-1:0]   eff;
  logic [EN_W-1:0]   slow_en;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] flag_set;
  logic [FLAG_W-1:0] flag_hwclr;

  assign busy      = pend_q | inflight;
  assign run_wr_ok = wr_en_i & key_q & ~busy;

  always_comb begin
    shadow_d = shadow_q;
    if (run_wr_ok) shadow_d[E_RUN] = wr_data_i[B_RUN];
    if (wr_en_i) begin
      shadow_d[E_LEN] = wr_data_i[B_LEN];
      shadow_d[E_SEN] = wr_data_i[B_SEN];
    end
  end

  assign en_change = wr_en_i & (shadow_d != shadow_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q    <= 1'b0;
      rdy_ie_q <= 1'b0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      if (wr_en_i) begin
        key_q    <= wr_data_i[B_KEY];
        rdy_ie_q <= wr_data_i[B_RDYIE];
      end
      if (en_change)   pend_q <= 1'b1;
      else if (launch) pend_q <= 1'b0;
    end
  end

  tcr_xfer #(.W(EN_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slow_clk_i  (slow_clk_i),
    .slow_rst_ni (slow_rst_ni),
    .pend_i      (pend_q),
    .data_i      (shadow_q),
    .launch_o    (launch),
    .inflight_o  (inflight),
    .eff_o       (eff),
    .slow_o      (slow_en)
  );

  assign flag_set[F_RDY]   = cnt_upd_i;
  assign flag_set[F_LNG]   = alm_long_i;
  assign flag_set[F_SHT]   = alm_short_i;
  assign flag_hwclr[F_RDY] = cnt_pre_i;
  assign flag_hwclr[F_LNG] = 1'b0;
  assign flag_hwclr[F_SHT] = 1'b0;

  generate
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      localparam int POS = flag_pos(i);
      tcr_flag u_flag (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (flag_set[i]),
        .hw_clr_i (flag_hwclr[i]),
        .sw_wr_i  (wr_en_i),
        .sw_val_i (wr_data_i[POS]),
        .flag_o   (flags[i])
      );
    end
  endgenerate

  assign rd_data_o  = pack_reg(shadow_q, busy, flags, rdy_ie_q, key_q);
  assign irq_o      = irq_calc(flags, eff, rdy_ie_q);
  assign wake_o     = flags[F_LNG] | flags[F_SHT];
  assign run_o      = slow_en[E_RUN];
  assign long_en_o  = slow_en[E_LEN];
  assign short_en_o = slow_en[E_SEN];

  // R2: a guarded run write leaves the run bit as it was
  p_run_guard_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(key_q && !busy)) |=> (rd_data_o[B_RUN] == $past(shadow_q[E_RUN])));

  // R4: a changing enable write shows busy from the next cycle
  p_busy_raise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_change |=> rd_data_o[B_BUSY]);

  // R5 / R6: once busy drops, the effective enables match the written ones
  p_eff_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (eff == shadow_q));

  // R11: the unused bits never read as 1
  p_unused_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_KEY-1:B_SFLAG+1] == '0);
endmodule

// File: tb/tcr_ctl_tb_top.sv
module tcr_ctl_tb_top;
  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        cnt_pre = 1'b0;
  logic        cnt_upd = 1'b0;
  logic        alm_long = 1'b0;
  logic        alm_short = 1'b0;
  logic        run, long_en, short_en, irq, wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always #18.5 slow_clk = ~slow_clk;

  tcr_ctl #(.SYNC_STAGES(2)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .slow_clk_i  (slow_clk),
    .slow_rst_ni (slow_rst_n),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .cnt_pre_i   (cnt_pre),
    .cnt_upd_i   (cnt_upd),
    .alm_long_i  (alm_long),
    .alm_short_i (alm_short),
    .run_o       (run),
    .long_en_o   (long_en),
    .short_en_o  (short_en),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a write for one cycle; state is visible at the following negedge
  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cnt_pre = 1'b1;
      1: cnt_upd = 1'b1;
      2: alm_long = 1'b1;
      default: alm_short = 1'b1;
    endcase
    @(negedge clk);
    cnt_pre = 1'b0; cnt_upd = 1'b0; alm_long = 1'b0; alm_short = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (rd_data[3] == 1'b0) return;
      @(negedge clk);
    end
    chk("R4 busy timeout", rd_data[3], 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 reg", rd_data, 16'h0000);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wake", wake, 1'b0);
    chk("R1 slow", {run, long_en, short_en}, 3'b000);
  endtask

  task automatic t_unused();
    wr(16'h7F00);
    chk("R11 unused", rd_data, 16'h0000);
  endtask

  task automatic t_guard();
    wr(16'h0001);                        // key is 0: run write dropped
    chk("R2 no key", rd_data[0], 1'b0);
    chk("R4 no change no busy", rd_data[3], 1'b0);
    wr(16'h8000);                        // set key
    chk("R3 key", rd_data[15], 1'b1);
    wr(16'h8001);
    chk("R3 run accepted", rd_data[0], 1'b1);
    chk("R4 busy raised", rd_data[3], 1'b1);
    wait_idle();
    chk("R5 run out", run, 1'b1);
    wr(16'h8000);
    wait_idle();
    chk("R5 run cleared", run, 1'b0);
    wr(16'h8002);                        // long enable change -> busy
    chk("R4 busy long", rd_data[3], 1'b1);
    wr(16'h8003);                        // run write while busy: dropped
    chk("R2 busy drop", rd_data[0], 1'b0);
    wait_idle();
    chk("R5 slow", {run, long_en, short_en}, 3'b010);
    wr(16'h800A);                        // bit 3 written, no enable change
    chk("R4 read-only busy", rd_data[3], 1'b0);
  endtask

  task automatic t_alarm_gate();
    pulse(2);
    chk("R8 long set", rd_data[6], 1'b1);
    chk("R9 irq long", irq, 1'b1);
    chk("R10 wake", wake, 1'b1);
    wr(16'h8040);                        // drop long enable, keep flag
    chk("R6 old enable", irq, 1'b1);
    wait_idle();
    chk("R6 new enable", irq, 1'b0);
    chk("R10 wake ungated", wake, 1'b1);
    chk("R8 write1 keep", rd_data[6], 1'b1);
    wr(16'h8000);
    chk("R8 long clear", rd_data[6], 1'b0);
    chk("R10 wake low", wake, 1'b0);
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h8000; alm_short = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; alm_short = 1'b0;
    chk("R8 set wins", rd_data[7], 1'b1);
    chk("R9 short disabled", irq, 1'b0);
    wr(16'h8084);
    wait_idle();
    chk("R9 irq short", irq, 1'b1);
    wr(16'h8004);
    chk("R8 short clear", rd_data[7], 1'b0);
  endtask

  task automatic t_ready();
    pulse(1);
    chk("R7 ready set", rd_data[4], 1'b1);
    chk("R9 ready no ie", irq, 1'b0);
    wr(16'h8034);
    chk("R9 ready irq", irq, 1'b1);
    pulse(0);
    chk("R7 pre clear", rd_data[4], 1'b0);
    chk("R9 irq drop", irq, 1'b0);
    pulse(1);
    wr(16'h8024);
    chk("R7 sw clear", rd_data[4], 1'b0);
    wr(16'h8034);
    chk("R7 write1 no set", rd_data[4], 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h8024; cnt_upd = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_upd = 1'b0;
    chk("R12 upd over sw", rd_data[4], 1'b1);
    @(negedge clk);
    cnt_pre = 1'b1; cnt_upd = 1'b1;
    @(negedge clk);
    cnt_pre = 1'b0; cnt_upd = 1'b0;
    chk("R12 upd over pre", rd_data[4], 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1; slow_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unused();
    t_guard();
    t_alarm_gate();
    t_set_wins();
    t_ready();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      if (done) break;
      @(posedge clk);
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule